// File: doc/BRIEF.md
# Converter Start-Up Sequencer with Overflow Flag

This block sequences the digital back end of a multi-channel converter out of power-down. While the active-low power-down input is low, the decimation filter is held in reset, the sample path is forced to zero and the serial outputs are held low. In master mode the bit and frame clocks are also held low. After the input rises, the block counts frame-sync edges. It releases the sample path once the count for the selected clocking mode is reached: 516 edges as clock master, 517 edges as clock slave.

In parallel, every incoming sample is checked against a near-full-scale threshold. The result for all channels is combined into one bit per frame. That bit is delayed by the filter's group delay so that the flag lines up with the filtered data. The flag stays blanked until detection has been enabled. A monitor checks the frame-sync period against the master clock. If the period is wrong, the monitor resets the filter and starts the initialization count again.

Top module: `conv_init_seq`

## Requirements
- R1: While the synchronized power-down input is low, filt_rst_o=1, zero_force_o=1, out_vld_o=0, ovf_o=0 and ser_low_o=1. clk_low_o equals master_i in that state.
- R2: With master_i=1, out_vld_o rises and zero_force_o falls on the 516th counted frame-sync edge after the sequencer leaves power-down.
- R3: With master_i=0, the same happens on the 517th counted edge.
- R4: The counted edge is the falling edge of fsync_i only when i2s_i=1 and master_i=0. Otherwise the rising edge is counted.
- R5: A sample counts as overflowed when its two's-complement magnitude is greater than 8103886. The code -8388608 saturates to 8388607 and therefore counts. A magnitude of exactly 8103886 does not count.
- R6: ovf_o is the OR of all channels over one frame. It appears 13 counted edges after the frame in which the sample arrived, lasts one frame and is not latched.
- R7: ovf_o stays 0 until the 516th counted edge after power-down release, in either clocking mode.
- R8: Once the first edge has been counted, any counted edge that arrives other than FRAME_CLKS clocks after the previous one is treated as lost phase. A missing edge at that point is treated the same way. Lost phase gives one clock with filt_rst_o=1, drops out_vld_o and restarts the count from zero. The edge that revealed the loss is not counted.
- R9: The power-down input passes through a two-flop synchronizer. A change is seen on the outputs after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Active-low power-down pin, asynchronous |
| fsync_i | input | 1 | Frame sync, synchronous to clk_i |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| i2s_i | input | 1 | 1 = I2S-style framing |
| smp_i | input | NCH*SW | Channel samples, channel c at bits c*SW and up |
| smp_vld_i | input | 1 | Sample strobe |
| zero_force_o | output | 1 | Force sample path to zero |
| filt_rst_o | output | 1 | Decimation filter reset |
| out_vld_o | output | 1 | Output data valid |
| ovf_o | output | 1 | Delayed per-frame overflow flag |
| ser_low_o | output | 1 | Hold serial data outputs low |
| clk_low_o | output | 1 | Hold bit and frame clocks low (master only) |

## Verification
The assertions assume three things about the inputs. First, master_i and i2s_i change only while the block is powered down. Second, fsync_i is already synchronous to the master clock. Third, at most one counted edge occurs per FRAME_CLKS window.

The stimulus respects these assumptions. It changes the mode inputs only after holding the power-down input low for several clocks. It generates frame sync as a square wave of exactly FRAME_CLKS clocks. One deliberately short frame is used to exercise the lost-phase path.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_INIT   = 2'd1,
    ST_RUN    = 2'd2,
    ST_RESYNC = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cis_sync2.sv
module cis_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/cis_frame_mon.sv
module cis_frame_mon #(
  parameter int unsigned FRAME_CLKS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic fall_sel_i,
  input  logic track_i,
  output logic act_edge_o,
  output logic lost_o
);
  localparam int unsigned TW = (FRAME_CLKS > 2) ? $clog2(FRAME_CLKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(FRAME_CLKS - 1);

  logic          fsync_q;
  logic          locked_q;
  logic [TW-1:0] tmr_q;

  assign act_edge_o = fall_sel_i ? (fsync_q & ~fsync_i) : (fsync_i & ~fsync_q);
  // edge must coincide exactly with the end of the expected frame window
  assign lost_o = track_i & locked_q & (act_edge_o != (tmr_q == T_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q  <= 1'b0;
      locked_q <= 1'b0;
      tmr_q    <= '0;
    end else begin
      fsync_q <= fsync_i;
      if (!track_i || lost_o) begin
        locked_q <= 1'b0;
        tmr_q    <= '0;
      end else if (act_edge_o) begin
        locked_q <= 1'b1;
        tmr_q    <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cis_ovf_det.sv
module cis_ovf_det #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned SW     = 24,
  parameter int unsigned THRESH = 8103886,
  parameter int unsigned DLY    = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic            smp_vld_i,
  input  logic            push_i,
  output logic            ovf_dly_o
);
  localparam logic [SW-1:0] THR    = SW'(THRESH);
  localparam logic [SW-1:0] NEG_FS = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] POS_FS = {1'b0, {(SW-1){1'b1}}};

  logic [NCH-1:0] over;
  logic           acc_q;
  logic [DLY-1:0] dly_q;
  logic           hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] x, mag;
    assign x = smp_i[c*SW +: SW];
    always_comb begin
      if (!x[SW-1])      mag = x;
      else if (x == NEG_FS) mag = POS_FS;
      else               mag = ~x + 1'b1;
    end
    assign over[c] = (mag > THR);
  end

  assign hit = smp_vld_i & (|over);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      dly_q <= '0;
    end else if (clr_i) begin
      acc_q <= 1'b0;
      dly_q <= '0;
    end else if (push_i) begin
      acc_q <= 1'b0;
      if (DLY > 1) dly_q <= {dly_q[DLY-2:0], acc_q | hit};
      else         dly_q <= DLY'(acc_q | hit);
    end else begin
      acc_q <= acc_q | hit;
    end
  end

  assign ovf_dly_o = dly_q[DLY-1];
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned SW         = 24,
  parameter int unsigned FRAME_CLKS = 256,
  parameter int unsigned MST_FRAMES = 516,
  parameter int unsigned SLV_FRAMES = 517,
  parameter int unsigned OVF_BLANK  = 516,
  parameter int unsigned OVF_DLY    = 13,
  parameter int unsigned OVF_THRESH = 8103886
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_up_i,
  input  logic              fsync_i,
  input  logic              master_i,
  input  logic              i2s_i,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic              smp_vld_i,
  output logic              zero_force_o,
  output logic              filt_rst_o,
  output logic              out_vld_o,
  output logic              ovf_o,
  output logic              ser_low_o,
  output logic              clk_low_o
);
  import conv_init_pkg::*;

  localparam int unsigned MAXF = (MST_FRAMES > SLV_FRAMES) ? MST_FRAMES : SLV_FRAMES;
  localparam int unsigned CW   = $clog2(MAXF + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt_q;
  logic          ovf_en;
  logic          pu_s;
  logic          act_edge, lost, track, ovf_raw;
  logic [CW-1:0] lim_m1;

  cis_sync2 u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_up_i),
    .q_o   (pu_s)
  );

  assign track = (state == ST_INIT) || (state == ST_RUN);

  cis_frame_mon #(.FRAME_CLKS(FRAME_CLKS)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .fall_sel_i(i2s_i & ~master_i),
    .track_i   (track),
    .act_edge_o(act_edge),
    .lost_o    (lost)
  );

  cis_ovf_det #(.NCH(NCH), .SW(SW), .THRESH(OVF_THRESH), .DLY(OVF_DLY)) u_ovf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~track),
    .smp_i    (smp_i),
    .smp_vld_i(smp_vld_i),
    .push_i   (act_edge),
    .ovf_dly_o(ovf_raw)
  );

  assign lim_m1 = master_i ? CW'(MST_FRAMES - 1) : CW'(SLV_FRAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_OFF;
      cnt_q  <= '0;
      ovf_en <= 1'b0;
    end else if (!pu_s) begin
      state  <= ST_OFF;
      cnt_q  <= '0;
      ovf_en <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF: state <= ST_INIT;
        ST_INIT: begin
          if (lost) state <= ST_RESYNC;
          else if (act_edge) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(OVF_BLANK - 1)) ovf_en <= 1'b1;
            if (cnt_q == lim_m1) state <= ST_RUN;
          end
        end
        ST_RUN: if (lost) state <= ST_RESYNC;
        ST_RESYNC: begin
          state  <= ST_INIT;
          cnt_q  <= '0;
          ovf_en <= 1'b0;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign out_vld_o    = (state == ST_RUN);
  assign zero_force_o = ~out_vld_o;
  assign filt_rst_o   = (state == ST_OFF) || (state == ST_RESYNC);
  assign ser_low_o    = (state == ST_OFF);
  assign clk_low_o    = ser_low_o & master_i;
  assign ovf_o        = ovf_en & ovf_raw;
endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic zero_force_o,
  input logic filt_rst_o,
  input logic out_vld_o,
  input logic ovf_o,
  input logic ser_low_o,
  input logic clk_low_o,
  input logic act_edge,
  input logic lost
);
  p_off_outputs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_low_o |-> (filt_rst_o && zero_force_o && !out_vld_o && !ovf_o));

  p_clk_low_master_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_low_o |-> (ser_low_o && master_i));

  p_vld_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_o) |-> $past(act_edge));

  p_ovf_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(act_edge));

  p_ovf_master_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && master_i) |-> out_vld_o);

  p_lost_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost |=> (filt_rst_o && !out_vld_o));
endmodule

bind conv_init_seq conv_init_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_i    (master_i),
  .zero_force_o(zero_force_o),
  .filt_rst_o  (filt_rst_o),
  .out_vld_o   (out_vld_o),
  .ovf_o       (ovf_o),
  .ser_low_o   (ser_low_o),
  .clk_low_o   (clk_low_o),
  .act_edge    (act_edge),
  .lost        (lost)
);

// File: tb/conv_init_seq_tb_top.sv
module conv_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SW  = 24;
  localparam int F   = 8;
  localparam int THR = 8103886;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pu = 1'b0, fsync = 1'b0, master = 1'b1, i2s = 1'b0, vld = 1'b0;
  logic [NCH*SW-1:0] smp = '0;
  logic zero_o, filt_o, outv_o, ovf_o, serl_o, clkl_o;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_init_seq #(.NCH(NCH), .SW(SW), .FRAME_CLKS(F)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pu), .fsync_i(fsync),
    .master_i(master), .i2s_i(i2s), .smp_i(smp), .smp_vld_i(vld),
    .zero_force_o(zero_o), .filt_rst_o(filt_o), .out_vld_o(outv_o),
    .ovf_o(ovf_o), .ser_low_o(serl_o), .clk_low_o(clkl_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_pa, m_pb, m_fprev, m_en, m_lock, m_acc;
  int m_st, m_cnt, m_tmr;
  bit m_dq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_fprev = 0; m_en = 0; m_lock = 0; m_acc = 0;
      m_st = 0; m_cnt = 0; m_tmr = 0;
      m_dq = {};
      for (int k = 0; k < 13; k++) m_dq.push_back(1'b0);
    end else begin
      bit e, ls, trk, hit;
      int st0, lim;
      st0 = m_st;
      e   = (i2s && !master) ? (!fsync && m_fprev) : (fsync && !m_fprev);
      trk = (st0 == 1 || st0 == 2);
      ls  = trk && m_lock && (e != (m_tmr == F-1));
      hit = 0;
      for (int c = 0; c < NCH; c++) begin
        int v, a;
        v = int'($signed(smp[c*SW +: SW]));
        a = (v < 0) ? -v : v;
        if (vld && a > THR) hit = 1;
      end
      lim = master ? 516 : 517;
      if (!trk || ls) begin m_lock = 0; m_tmr = 0; end
      else if (e) begin m_lock = 1; m_tmr = 0; end
      else m_tmr++;
      if (!trk) begin
        m_acc = 0;
        foreach (m_dq[k]) m_dq[k] = 0;
      end else if (e) begin
        m_dq.push_front(m_acc | hit);
        void'(m_dq.pop_back());
        m_acc = 0;
      end else m_acc = m_acc | hit;
      if (!m_pb) begin m_st = 0; m_cnt = 0; m_en = 0; end
      else case (st0)
        0: m_st = 1;
        1: if (ls) m_st = 3;
           else if (e) begin
             m_cnt++;
             if (m_cnt == 516) m_en = 1;
             if (m_cnt == lim) m_st = 2;
           end
        2: if (ls) m_st = 3;
        default: begin m_st = 1; m_cnt = 0; m_en = 0; end
      endcase
      m_fprev = fsync;
      m_pb = m_pa;
      m_pa = pu;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      chk(outv_o == (m_st == 2), "R2/R3 out_vld", outv_o, m_st == 2);
      chk(zero_o == (m_st != 2), "R2 zero_force", zero_o, m_st != 2);
      chk(filt_o == (m_st == 0 || m_st == 3), "R8 filt_rst", filt_o, m_st == 0 || m_st == 3);
      chk(serl_o == (m_st == 0), "R1 ser_low", serl_o, m_st == 0);
      chk(clkl_o == (m_st == 0 && master), "R1 clk_low", clkl_o, m_st == 0 && master);
      chk(ovf_o == (m_en && m_dq[12]), "R6 ovf", ovf_o, m_en && m_dq[12]);
    end
  end

  // ---------------- stimulus ----------------
  bit last_ovf;

  task automatic frame(input int len, input bit inj, input int ch, input int val);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == len-1) last_ovf = ovf_o;
      fsync = (i < len/2);
      vld   = (i == len/2);
      smp   = '0;
      for (int c = 0; c < NCH; c++) smp[c*SW +: SW] = SW'(100 * (c + 1));
      if (inj && i == len/2) smp[ch*SW +: SW] = SW'(val);
    end
  endtask

  task automatic frames(input int n, input bit inj);
    for (int k = 0; k < n; k++) frame(F, inj, 1, 8388607);
  endtask

  task automatic power_up(input bit m, input bit fmt);
    @(negedge clk); pu = 0; fsync = 0; vld = 0;
    repeat (3) @(negedge clk);
    master = m; i2s = fmt;
    repeat (2) @(negedge clk);
    chk(filt_o && serl_o && zero_o && !outv_o && !ovf_o, "R1 powered down", filt_o, 1);
    chk(clkl_o == m, "R1 clk_low by mode", clkl_o, m);
    pu = 1;
    @(negedge clk); @(negedge clk);
    chk(filt_o == 1, "R9 still off after two edges", filt_o, 1);
    @(negedge clk);
    chk(filt_o == 0, "R9 leaves off after third edge", filt_o, 0);
  endtask

  // inject one sample, expect flag only in frame 13 when over
  task automatic ovf_probe(input int ch, input int val, input bit exp_over);
    int seen_at, seen_n;
    seen_at = -1; seen_n = 0;
    frame(F, 1, ch, val);
    for (int k = 1; k <= 15; k++) begin
      frame(F, 0, 0, 0);
      if (last_ovf) begin seen_n++; if (seen_at < 0) seen_at = k; end
    end
    if (exp_over) begin
      chk(seen_at == 13, "R6 delay of 13 frames", seen_at, 13);
      chk(seen_n == 1, "R6 one frame, not latched", seen_n, 1);
    end else
      chk(seen_n == 0, "R5 at or below threshold", seen_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(filt_o && zero_o && !outv_o && !ovf_o && serl_o && clkl_o, "R1 reset state", filt_o, 1);
    rst_n = 1;
    cmp_on = 1;
    // master, rising edge, overflow present during whole init
    power_up(1, 0);
    frames(515, 1);
    chk(outv_o == 0, "R2 not valid after 515", outv_o, 0);
    chk(ovf_o == 0, "R7 blanked after 515", ovf_o, 0);
    frames(1, 1);
    chk(outv_o == 1, "R2 valid after 516", outv_o, 1);
    chk(ovf_o == 1, "R7 enabled after 516", ovf_o, 1);
    frames(14, 0);
    chk(ovf_o == 0, "R6 clears when input clean", ovf_o, 0);
    // threshold corners
    ovf_probe(0, THR, 0);
    ovf_probe(1, THR + 1, 1);
    ovf_probe(2, -THR, 0);
    ovf_probe(3, -THR - 1, 1);
    ovf_probe(2, -8388608, 1);
    ovf_probe(3, 8388607, 1);
    // lost phase: short frame, then next edge arrives early
    frame(F/2, 0, 0, 0);
    frame(F, 0, 0, 0);
    chk(outv_o == 0, "R8 valid drops on lost phase", outv_o, 0);
    frames(515, 0);
    chk(outv_o == 0, "R8 restart count 515", outv_o, 0);
    frames(1, 0);
    chk(outv_o == 1, "R8 valid after full restart", outv_o, 1);
    // slave, I2S: falling edges, one more frame
    power_up(0, 1);
    frames(516, 1);
    chk(outv_o == 0, "R3 not valid after 516", outv_o, 0);
    chk(ovf_o == 1, "R7 slave ovf enabled at 516", ovf_o, 1);
    frames(1, 0);
    chk(outv_o == 1, "R3 valid after 517", outv_o, 1);
    // master, I2S: still rising edges, 516
    power_up(1, 1);
    frames(516, 0);
    chk(outv_o == 1, "R4 master I2S counts rising, 516", outv_o, 1);
    frames(3, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule